// File: doc/BRIEF.md
# Precise Exception Status Tracker

This block follows every instruction of a five-stage in-order pipeline with a small fault record: a valid flag, the instruction's PC and a set of cause bits. Each stage adds the causes it detects to the record of the instruction it currently holds, and the record moves forward with the instruction. Nothing is acted upon early. Only when an instruction sits in write-back does the block look at its record. A non-empty record makes the block take a trap.

When a trap is taken, the block stores the instruction's PC and a 4-bit cause code. It discards every younger instruction and steers the next fetch to a fixed trap address. An instruction with a recorded fault never writes the register file. The memory write of an instruction in the memory stage is also blocked when that instruction has a fault, or when an older instruction is trapping in the same cycle. Because of this, neither the faulting instruction nor anything behind it changes machine state, and the restart PC is exact.

The block also owns the fetch PC. That PC advances by a fixed step. It can be held, redirected by a branch, or reloaded from a restore input used for the return from a handler. A trap outranks all of these.

Top module: `exc_tracker`

## Requirements
- R1: After reset, `fetch_pc` equals RESET_PC (0), `epc` and `cause_code` are 0, and `trap_take`, `rf_wr_en` and `mem_wr_en` are low.
- R2: If no trap, restore or redirect is active, `fetch_pc` moves to `fetch_pc`+4 on each edge where `hold` is low, and keeps its value where `hold` is high. With `redirect` high, it loads `redirect_pc`.
- R3: Each fetched instruction moves IF→ID→EX→MEM→WB, one stage per edge where `hold` is low. The cause inputs of a stage are added to the instruction in that stage on the advancing edge. `trap_take` is high in a cycle exactly when the WB instruction is valid and has at least one cause recorded.
- R4: Cause codes are assigned as follows: 1 fetch page fault (`if_fault[0]`), 2 fetch misaligned (`if_fault[1]`), 3 fetch protection (`if_fault[2]`), 4 illegal opcode, 5 arithmetic, 6 data page fault (`mem_fault[0]`), 7 data misaligned (`mem_fault[1]`), 8 data protection (`mem_fault[2]`). If one instruction carries several causes, the lowest code is stored.
- R5: Traps follow program order. An older instruction's MEM fault is reported before a fault that a younger instruction raised in an earlier stage during the same cycle.
- R6: `rf_wr_en` equals `rf_wr_req` for a valid WB instruction with no recorded cause, and is low otherwise.
- R7: `mem_wr_en` equals `mem_wr_req` only when the MEM instruction is valid, has no cause (including a `mem_fault` bit raised in this cycle), and `trap_take` is low.
- R8: On the edge after a cycle with `trap_take`, `epc` holds the trapping PC and `cause_code` holds its code. The instructions that were in flight never trap and never write.
- R9: On the edge after `trap_take`, `fetch_pc` becomes TRAP_VEC (0x100), whatever `hold`, `redirect` and `restore` are.
- R10: If no trap is taken, `restore` loads `restore_pc` into `fetch_pc`, and it overrides `redirect` and `hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Freeze the pipeline stages and the fetch PC |
| redirect | input | 1 | Branch redirect request |
| redirect_pc | input | 32 | Branch target |
| restore | input | 1 | Resume request after a handler |
| restore_pc | input | 32 | PC to resume at |
| if_fault | input | 3 | Fetch causes of the instruction at `fetch_pc` |
| id_illegal | input | 1 | Illegal opcode in ID |
| ex_arith | input | 1 | Arithmetic fault in EX |
| mem_fault | input | 3 | Data access causes in MEM |
| mem_wr_req | input | 1 | MEM instruction wants a memory write |
| rf_wr_req | input | 1 | WB instruction wants a register write |
| fetch_pc | output | 32 | Current fetch address |
| mem_wr_en | output | 1 | Gated memory write enable |
| rf_wr_en | output | 1 | Gated register-file write enable |
| trap_take | output | 1 | Trap taken this cycle (flush) |
| epc | output | 32 | Saved PC of the trapping instruction |
| cause_code | output | 4 | Saved cause code |

## Verification
Seeded random traffic is used. Each stage fault is sparse, and holds, redirects and restores are scattered in. Several instructions in flight can each carry faults, so the bench can check that records stay attached to their own instruction as stalls freeze the stages. Directed cases cover three situations. In the first, an older memory fault coincides with younger EX and ID faults, which separates program order from detection order. In the second, one instruction carries two fetch causes and a later arithmetic cause, which tests priority inside a single record. In the third, a trap lands together with hold and redirect, which shows whether the trap fetch outranks them.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NCAUSE = 8;
  localparam int CB_IF_PF   = 0;
  localparam int CB_IF_MIS  = 1;
  localparam int CB_IF_PROT = 2;
  localparam int CB_ID_ILL  = 3;
  localparam int CB_EX_AR   = 4;
  localparam int CB_MEM_PF  = 5;
  localparam int CB_MEM_MIS = 6;
  localparam int CB_MEM_PRT = 7;

  typedef logic [NCAUSE-1:0] cause_vec_t;
  typedef logic [3:0]        cause_code_t;

  // Lowest bit position wins; code is position plus one, zero when empty.
  function automatic cause_code_t pick_code(cause_vec_t v);
    cause_code_t c;
    c = '0;
    for (int i = NCAUSE - 1; i >= 0; i--) begin
      if (v[i]) c = cause_code_t'(i + 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      s1    <= 1'b1;
      rst_q <= s1;
    end
  end
endmodule

// File: rtl/exc_stage.sv
module exc_stage
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            flush,
  input  logic            in_v,
  input  logic [PC_W-1:0] in_pc,
  input  cause_vec_t      in_vec,
  input  cause_vec_t      add_vec,
  output logic            q_v,
  output logic [PC_W-1:0] q_pc,
  output cause_vec_t      q_vec
);
  logic            en;
  logic            d_v;
  logic [PC_W-1:0] d_pc;
  cause_vec_t      d_vec;

  always_comb begin
    en    = flush | adv;
    d_v   = in_v & ~flush;
    d_pc  = in_pc;
    d_vec = (in_v && !flush) ? (in_vec | add_vec) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v   <= 1'b0;
      q_pc  <= '0;
      q_vec <= '0;
    end else if (en) begin
      q_v   <= d_v;
      q_pc  <= d_pc;
      q_vec <= d_vec;
    end
  end
endmodule

// File: rtl/exc_fetch_sel.sv
module exc_fetch_sel #(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  parameter logic [PC_W-1:0] TRAP_VEC = 'h100,
  parameter int              PC_STEP  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            restore,
  input  logic [PC_W-1:0] restore_pc,
  input  logic            redirect,
  input  logic [PC_W-1:0] redirect_pc,
  input  logic            hold,
  output logic [PC_W-1:0] pc_q
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);
  logic [PC_W-1:0] pc_d;

  always_comb begin
    if (take)          pc_d = TRAP_VEC;
    else if (restore)  pc_d = restore_pc;
    else if (redirect) pc_d = redirect_pc;
    else if (hold)     pc_d = pc_q;
    else               pc_d = pc_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/exc_tracker.sv
module exc_tracker
  import exc_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  parameter logic [PC_W-1:0] TRAP_VEC = 'h100,
  parameter int              PC_STEP  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            redirect,
  input  logic [PC_W-1:0] redirect_pc,
  input  logic            restore,
  input  logic [PC_W-1:0] restore_pc,
  input  logic [2:0]      if_fault,
  input  logic            id_illegal,
  input  logic            ex_arith,
  input  logic [2:0]      mem_fault,
  input  logic            mem_wr_req,
  input  logic            rf_wr_req,
  output logic [PC_W-1:0] fetch_pc,
  output logic            mem_wr_en,
  output logic            rf_wr_en,
  output logic            trap_take,
  output logic [PC_W-1:0] epc,
  output logic [3:0]      cause_code
);
  localparam int NSTG = 4;          // ID, EX, MEM, WB records
  localparam int S_MEM = NSTG - 1;
  localparam int S_WB  = NSTG;

  logic rst_q;
  logic adv;

  logic            st_v   [0:NSTG];
  logic [PC_W-1:0] st_pc  [0:NSTG];
  cause_vec_t      st_vec [0:NSTG];
  cause_vec_t      add_v  [0:NSTG-1];

  exc_rst_sync u_rsync (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  assign adv       = ~hold;
  assign st_v[0]   = 1'b1;
  assign st_pc[0]  = fetch_pc;
  assign st_vec[0] = '0;

  // Causes detected by each stage for the instruction it holds now.
  always_comb begin
    for (int k = 0; k < NSTG; k++) add_v[k] = '0;
    add_v[0][CB_IF_PF]   = if_fault[0];
    add_v[0][CB_IF_MIS]  = if_fault[1];
    add_v[0][CB_IF_PROT] = if_fault[2];
    add_v[1][CB_ID_ILL]  = id_illegal;
    add_v[2][CB_EX_AR]   = ex_arith;
    add_v[3][CB_MEM_PF]  = mem_fault[0];
    add_v[3][CB_MEM_MIS] = mem_fault[1];
    add_v[3][CB_MEM_PRT] = mem_fault[2];
  end

  for (genvar k = 1; k <= NSTG; k++) begin : g_stg
    exc_stage #(.PC_W(PC_W)) u_stg (
      .clk(clk), .rst_n(rst_q), .adv(adv), .flush(trap_take),
      .in_v(st_v[k-1]), .in_pc(st_pc[k-1]), .in_vec(st_vec[k-1]),
      .add_vec(add_v[k-1]),
      .q_v(st_v[k]), .q_pc(st_pc[k]), .q_vec(st_vec[k])
    );
  end

  assign trap_take = st_v[S_WB] & (|st_vec[S_WB]);
  assign rf_wr_en  = rf_wr_req & st_v[S_WB] & ~(|st_vec[S_WB]);
  assign mem_wr_en = mem_wr_req & st_v[S_MEM]
                   & ~(|(st_vec[S_MEM] | add_v[S_MEM])) & ~trap_take;

  exc_fetch_sel #(
    .PC_W(PC_W), .RESET_PC(RESET_PC), .TRAP_VEC(TRAP_VEC), .PC_STEP(PC_STEP)
  ) u_fsel (
    .clk(clk), .rst_n(rst_q), .take(trap_take),
    .restore(restore), .restore_pc(restore_pc),
    .redirect(redirect), .redirect_pc(redirect_pc),
    .hold(hold), .pc_q(fetch_pc)
  );

  // Saved trap state: written only in the flush cycle.
  logic [PC_W-1:0] epc_d;
  cause_code_t     code_d;
  always_comb begin
    epc_d  = st_pc[S_WB];
    code_d = pick_code(st_vec[S_WB]);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      epc        <= '0;
      cause_code <= '0;
    end else if (trap_take) begin
      epc        <= epc_d;
      cause_code <= code_d;
    end
  end
endmodule

// File: rtl/exc_tracker_chk.sv
module exc_tracker_chk #(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] TRAP_VEC = 'h100
) (
  input logic            clk,
  input logic            rst_q,
  input logic            trap_take,
  input logic [PC_W-1:0] fetch_pc,
  input logic            rf_wr_en,
  input logic            mem_wr_en,
  input logic [PC_W-1:0] epc,
  input logic [3:0]      cause_code,
  input logic [PC_W-1:0] wb_pc,
  input logic [7:0]      wb_vec,
  input logic            id_v,
  input logic            ex_v,
  input logic            mem_v,
  input logic            wb_v
);
  a_r9_trap_fetch: assert property (@(posedge clk) disable iff (!rst_q)
    trap_take |=> fetch_pc == TRAP_VEC);
  a_r8_epc_saved: assert property (@(posedge clk) disable iff (!rst_q)
    trap_take |=> epc == $past(wb_pc));
  a_r8_flush_all: assert property (@(posedge clk) disable iff (!rst_q)
    trap_take |=> !(id_v || ex_v || mem_v || wb_v));
  a_r8_epc_quiet: assert property (@(posedge clk) disable iff (!rst_q)
    !trap_take |=> $stable(epc) && $stable(cause_code));
  a_r4_code_set: assert property (@(posedge clk) disable iff (!rst_q)
    trap_take |=> cause_code != 4'd0);
  a_r6_rf_block: assert property (@(posedge clk) disable iff (!rst_q)
    (wb_vec != 8'd0) |-> !rf_wr_en);
  a_r7_mem_block: assert property (@(posedge clk) disable iff (!rst_q)
    trap_take |-> !mem_wr_en);
endmodule

bind exc_tracker exc_tracker_chk #(.PC_W(PC_W), .TRAP_VEC(TRAP_VEC)) u_chk (
  .clk(clk), .rst_q(rst_q), .trap_take(trap_take), .fetch_pc(fetch_pc),
  .rf_wr_en(rf_wr_en), .mem_wr_en(mem_wr_en), .epc(epc),
  .cause_code(cause_code), .wb_pc(st_pc[4]), .wb_vec(st_vec[4]),
  .id_v(st_v[1]), .ex_v(st_v[2]), .mem_v(st_v[3]), .wb_v(st_v[4])
);

// File: tb/exc_tracker_tb.sv
module exc_tracker_tb;
  localparam logic [31:0] TRAP = 32'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic        hold, redirect, restore, id_illegal, ex_arith, mem_wr_req, rf_wr_req;
  logic [31:0] redirect_pc, restore_pc;
  logic [2:0]  if_fault, mem_fault;
  logic [31:0] fetch_pc, epc;
  logic        mem_wr_en, rf_wr_en, trap_take;
  logic [3:0]  cause_code;

  exc_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .hold(hold), .redirect(redirect),
    .redirect_pc(redirect_pc), .restore(restore), .restore_pc(restore_pc),
    .if_fault(if_fault), .id_illegal(id_illegal), .ex_arith(ex_arith),
    .mem_fault(mem_fault), .mem_wr_req(mem_wr_req), .rf_wr_req(rf_wr_req),
    .fetch_pc(fetch_pc), .mem_wr_en(mem_wr_en), .rf_wr_en(rf_wr_en),
    .trap_take(trap_take), .epc(epc), .cause_code(cause_code)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // Reference state: index 1..4 = ID, EX, MEM, WB.
  bit          mv   [1:4];
  logic [31:0] mpc  [1:4];
  logic [7:0]  mvec [1:4];
  logic [31:0] mfpc, mepc;
  logic [3:0]  mcause;
  bit          last_take;

  function automatic logic [3:0] code_of(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return 4'(i + 1);
    return 4'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    hold = 0; redirect = 0; restore = 0; id_illegal = 0; ex_arith = 0;
    mem_wr_req = 0; rf_wr_req = 0; redirect_pc = '0; restore_pc = '0;
    if_fault = '0; mem_fault = '0;
  endtask

  task automatic rand_in();
    hold        = ($urandom % 8) == 0;
    redirect    = ($urandom % 8) == 0;
    restore     = ($urandom % 32) == 0;
    redirect_pc = {$urandom % 32'h1000, 2'b00};
    restore_pc  = {$urandom % 32'h1000, 2'b00};
    if_fault    = {($urandom % 24) == 0, ($urandom % 24) == 0, ($urandom % 24) == 0};
    id_illegal  = ($urandom % 16) == 0;
    ex_arith    = ($urandom % 16) == 0;
    mem_fault   = {($urandom % 24) == 0, ($urandom % 24) == 0, ($urandom % 24) == 0};
    mem_wr_req  = $urandom % 2;
    rf_wr_req   = $urandom % 2;
  endtask

  // One cycle: inputs already driven at a negedge.
  task automatic step();
    bit e_take, e_rf, e_mem;
    string ftag;
    #1;
    e_take = mv[4] && (mvec[4] != 0);
    e_rf   = rf_wr_req && mv[4] && (mvec[4] == 0);
    e_mem  = mem_wr_req && mv[3] && ((mvec[3] | {mem_fault, 5'b0}) == 0) && !e_take;
    chk("R3 trap_take", 32'(trap_take), 32'(e_take));
    chk("R6 rf_wr_en", 32'(rf_wr_en), 32'(e_rf));
    chk("R7 mem_wr_en", 32'(mem_wr_en), 32'(e_mem));
    ftag = e_take ? "R9 fetch_pc" : restore ? "R10 fetch_pc" : "R2 fetch_pc";
    @(posedge clk);
    if (e_take) begin
      mepc = mpc[4]; mcause = code_of(mvec[4]);
      for (int k = 1; k <= 4; k++) begin mv[k] = 0; mvec[k] = '0; end
      mfpc = TRAP;
    end else begin
      if (!hold) begin
        mv[4] = mv[3]; mpc[4] = mpc[3]; mvec[4] = mv[3] ? (mvec[3] | {mem_fault, 5'b0}) : 8'h0;
        mv[3] = mv[2]; mpc[3] = mpc[2]; mvec[3] = mv[2] ? (mvec[2] | {3'b0, ex_arith, 4'b0}) : 8'h0;
        mv[2] = mv[1]; mpc[2] = mpc[1]; mvec[2] = mv[1] ? (mvec[1] | {4'b0, id_illegal, 3'b0}) : 8'h0;
        mv[1] = 1; mpc[1] = mfpc; mvec[1] = {5'b0, if_fault};
      end
      mfpc = restore ? restore_pc : redirect ? redirect_pc : hold ? mfpc : mfpc + 32'd4;
    end
    last_take = e_take;
    @(negedge clk);
    chk(ftag, fetch_pc, mfpc);
    chk("R8 epc", epc, mepc);
    chk("R4 cause_code", 32'(cause_code), 32'(mcause));
  endtask

  initial begin
    void'($urandom(32'd4242));
    clear_in();
    for (int k = 1; k <= 4; k++) begin mv[k] = 0; mpc[k] = '0; mvec[k] = '0; end
    mfpc = '0; mepc = '0; mcause = '0; last_take = 0;
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    chk("R1 fetch_pc", fetch_pc, 32'h0);
    chk("R1 epc", epc, 32'h0);
    chk("R1 cause_code", 32'(cause_code), 32'h0);
    chk("R1 trap_take", 32'(trap_take), 32'h0);
    chk("R1 writes", 32'({rf_wr_en, mem_wr_en}), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);

    // R5: older MEM fault against younger EX and ID faults in the same cycle
    clear_in();
    repeat (5) step();
    mem_fault = 3'b001; ex_arith = 1; id_illegal = 1;
    step();
    clear_in();
    step();
    chk("R5 older wins code", 32'(cause_code), 32'd6);
    chk("R5 trap seen", 32'(last_take), 32'd1);
    chk("R9 trap fetch", fetch_pc, TRAP);

    // R4: two fetch causes plus later arithmetic on one instruction -> code 2
    repeat (4) step();
    if_fault = 3'b110;
    step();
    clear_in(); step();
    ex_arith = 1; step();
    clear_in(); step();
    // trap cycle, with hold and redirect also raised (R9 priority)
    hold = 1; redirect = 1; redirect_pc = 32'h444; rf_wr_req = 1;
    step();
    clear_in();
    chk("R4 lowest code", 32'(cause_code), 32'd2);
    chk("R9 over hold/redirect", fetch_pc, TRAP);

    // R10: restore over redirect
    restore = 1; restore_pc = 32'h2000; redirect = 1; redirect_pc = 32'h3000;
    step();
    clear_in();
    chk("R10 restore", fetch_pc, 32'h2000);

    for (int i = 0; i < 3000; i++) begin
      rand_in();
      step();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule